// File: doc/BRIEF.md
# Periodic Down-Count Tick Timer

This block is a memory-mapped down-counter that produces a periodic tick for an operating system scheduler or for delay loops. Software writes a reload value, then sets the run bit. The counter loads that value and decrements once per count tick. When it passes zero it raises a sticky wrap flag and, if interrupts are enabled, a one-cycle interrupt pulse. It then starts the next period from the reload value. A count tick is either every core clock or each cycle in which an external reference tick enable is high, as software selects.

Software talks to the block over a simple single-cycle 32-bit register port. Reads return data combinationally in the same cycle as the strobe, and read side effects take hold at the clock edge that ends the access. Any access marked unprivileged is refused with an error response.

Top module: `tick_timer`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control/status), 0x4 (reload), 0x8 (current value) and 0xC (calibration). Any other offset, including a non-word-aligned one, reads as zero, and writes to it change nothing.
- R2: In control/status, bit 0 is run, bit 1 is interrupt enable, bit 2 is source select and bit 16 is the wrap flag. A write changes only bits 2:0. The flag cannot be set by a write, and every other bit reads as zero.
- R3: A read of control/status returns the wrap flag as it stands and then clears it.
- R4: On expiry the wrap flag is set. If interrupt enable is 1, irq is high for exactly the one cycle after the expiring edge.
- R5: With a nonzero reload value R, expiries recur every R+1 count ticks and counting continues without software action.
- R6: If the reload value is zero when the counter expires, the run bit clears and counting stops.
- R7: With source select 1 the counter steps on every clock. With source select 0 it steps only on cycles where ref_tick is 1.
- R8: A write to current value clears the wrap flag. While running, it also restarts the count from the reload value.
- R9: Current value reads as zero while stopped. Clearing run freezes the count, and setting run again resumes from the frozen value. The count loads the reload value on start only if it is zero.
- R10: Changing source select while running forces the count to the reload value.
- R11: Calibration reads as the constant 10000, and writes to it are ignored.
- R12: Any access with bus_unpriv set returns bus_err = 1 with read data zero and changes no state.
- R13: Reset clears control, reload and count to zero. The reload register is 24 bits wide: bits 31:24 are dropped on write and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_unpriv | input | 1 | Access is unprivileged |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| bus_err | output | 1 | Error response for a refused access |
| ref_tick | input | 1 | Reference count-tick enable |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The main function is tried with a table of reload values and tick sources. Small and larger reloads run against the core clock, and against reference ticks at divide ratios of 2, 3 and 4. The bench measures the gap between two consecutive interrupts, which tells a correct R+1 period from one that is one tick off and from a counter that ignores the source choice. Directed sequences then stop the counter and restart it, change the source mid-count, and write the current value. These show apart a frozen count, a reloaded count and a zero read. Zero reload, refused unprivileged accesses and unmapped offsets are checked through the register reads that follow them.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int BUS_W    = 32;
    localparam int FLAG_POS = 16;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LOAD = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_CAL  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_CLEAR = 2'd2,
        CMD_COUNT = 2'd3
    } cnt_cmd_e;

    typedef struct packed {
        logic src;
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } access_t;

    function automatic logic [BUS_W-1:0] pack_status(ctrl_t c, logic flag);
        logic [BUS_W-1:0] v;
        v           = '0;
        v[2:0]      = c;
        v[FLAG_POS] = flag;
        return v;
    endfunction

endpackage

// File: rtl/tick_decode.sv
module tick_decode
    import tick_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic              unpriv,
    output access_t           acc,
    output logic              err
);
    logic in_map;

    // Only the four aligned words at the bottom of the window decode.
    assign in_map = (addr[ADDR_W-1:4] == '0) && (addr[1:0] == 2'b00);

    always_comb begin
        acc.sel = reg_sel_e'(addr[3:2]);
        acc.wr  = wr & ~unpriv & in_map;
        acc.rd  = rd & ~unpriv & in_map;
        err     = (wr | rd) & unpriv;
    end

endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_e         cmd,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);
    assign expire  = (cmd == CMD_COUNT) && step && at_zero;
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD:  cnt_q <= reload;
                CMD_CLEAR: cnt_q <= '0;
                CMD_COUNT: if (step) cnt_q <= at_zero ? reload : cnt_q - 1'b1;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    // R5
    reload_after_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt_q == $past(reload)));

    // R7
    hold_without_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_COUNT && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CNT_W     = 24,
    parameter int CAL_VALUE = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_unpriv,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic              ref_tick,
    output logic              irq
);
    localparam int PAD_W = BUS_W - CNT_W;

    access_t          acc;
    ctrl_t            ctrl_q, ctrl_new;
    logic             flag_q, irq_q;
    logic [CNT_W-1:0] reload_q, cnt;
    cnt_cmd_e         cmd;
    logic             step, expire;
    logic             ctrl_wr, load_wr, cur_wr, ctrl_rd;
    logic             wdata_unused;

    assign wdata_unused = ^bus_wdata[BUS_W-1:CNT_W];

    tick_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .unpriv (bus_unpriv),
        .acc    (acc),
        .err    (bus_err)
    );

    assign ctrl_wr  = acc.wr && acc.sel == SEL_CTRL;
    assign load_wr  = acc.wr && acc.sel == SEL_LOAD;
    assign cur_wr   = acc.wr && acc.sel == SEL_CUR;
    assign ctrl_rd  = acc.rd && acc.sel == SEL_CTRL;
    assign ctrl_new = ctrl_t'(bus_wdata[2:0]);
    assign step     = ctrl_q.src | ref_tick;

    // Counter command: run toggles win, then source change, then current write.
    always_comb begin
        if (ctrl_wr && ctrl_new.run != ctrl_q.run)
            cmd = (ctrl_new.run && cnt == '0) ? CMD_LOAD : CMD_HOLD;
        else if (ctrl_wr && ctrl_q.run && ctrl_new.src != ctrl_q.src)
            cmd = CMD_LOAD;
        else if (cur_wr)
            cmd = ctrl_q.run ? CMD_LOAD : CMD_CLEAR;
        else if (ctrl_q.run)
            cmd = CMD_COUNT;
        else
            cmd = CMD_HOLD;
    end

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .step   (step),
        .reload (reload_q),
        .cnt    (cnt),
        .expire (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            flag_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_new;
            if (expire && reload_q == '0) ctrl_q.run <= 1'b0;
            if (load_wr) reload_q <= bus_wdata[CNT_W-1:0];
            if (expire) flag_q <= 1'b1;
            else if (ctrl_rd || cur_wr) flag_q <= 1'b0;
            irq_q <= expire && ctrl_q.irq_en;
        end
    end

    assign irq = irq_q;

    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            unique case (acc.sel)
                SEL_CTRL: bus_rdata = pack_status(ctrl_q, flag_q);
                SEL_LOAD: bus_rdata = {{PAD_W{1'b0}}, reload_q};
                SEL_CUR:  bus_rdata = ctrl_q.run ? {{PAD_W{1'b0}}, cnt} : '0;
                default:  bus_rdata = BUS_W'(CAL_VALUE);
            endcase
        end
    end

    // R4
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);

    // R4
    flag_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);

    // R6
    zero_reload_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (expire && reload_q == '0) |=> !ctrl_q.run);

    // R12
    unpriv_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_unpriv) |=> $stable(reload_q));

endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;

    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_LOAD = 12'h004;
    localparam logic [11:0] A_CUR  = 12'h008;
    localparam logic [11:0] A_CAL  = 12'h00C;

    typedef struct packed {
        logic [31:0] reload;
        logic [31:0] src;
        logic [31:0] div;
        logic [31:0] gap;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'd3,  32'd1, 32'd0, 32'd4},
        '{32'd10, 32'd1, 32'd0, 32'd11},
        '{32'd2,  32'd0, 32'd3, 32'd9},
        '{32'd5,  32'd0, 32'd2, 32'd12},
        '{32'd7,  32'd0, 32'd4, 32'd32},
        '{32'd1,  32'd1, 32'd0, 32'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_unpriv = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        ref_tick = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    int refdiv = 0;
    int refcnt = 0;
    logic [31:0] rv;
    logic        ev;

    always #4 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_unpriv(bus_unpriv),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .ref_tick(ref_tick), .irq(irq)
    );

    always @(negedge clk) begin
        if (refdiv == 0) begin
            ref_tick = 1'b0;
            refcnt   = 0;
        end else begin
            ref_tick = (refcnt == 0);
            refcnt   = (refcnt + 1 >= refdiv) ? 0 : refcnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // Both tasks start and end at a falling edge and span one rising edge.
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic up, output logic e);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_unpriv = up;
        #1 e = bus_err;
        @(negedge clk);
        bus_wr = 1'b0; bus_unpriv = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic up, output logic [31:0] d, output logic e);
        bus_addr = a; bus_rd = 1'b1; bus_unpriv = up;
        #1 begin d = bus_rdata; e = bus_err; end
        @(negedge clk);
        bus_rd = 1'b0; bus_unpriv = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        rd(A_CTRL, 0, rv, ev); check("R13 ctrl after reset", rv, 32'h0);
        rd(A_LOAD, 0, rv, ev); check("R13 reload after reset", rv, 32'h0);
        rd(A_CUR,  0, rv, ev); check("R13 cur after reset", rv, 32'h0);
        // R13 reload width
        wr(A_LOAD, 32'hFFFF_FFFF, 0, ev);
        rd(A_LOAD, 0, rv, ev); check("R13 reload upper bits", rv, 32'h00FF_FFFF);
        // R11 calibration
        wr(A_CAL, 32'h1234, 0, ev);
        rd(A_CAL, 0, rv, ev); check("R11 calibration", rv, 32'd10000);
        // R1 unmapped and misaligned offsets
        wr(12'h010, 32'hFFFF, 0, ev);
        rd(12'h010, 0, rv, ev); check("R1 unmapped read", rv, 32'h0);
        rd(12'h006, 0, rv, ev); check("R1 misaligned read", rv, 32'h0);
        rd(A_LOAD, 0, rv, ev); check("R1 unmapped write no effect", rv, 32'h00FF_FFFF);
        // R2 only bits 2:0 writable
        wr(A_CTRL, 32'hFFFF_FFFA, 0, ev);
        rd(A_CTRL, 0, rv, ev); check("R2 ctrl write mask", rv, 32'h2);
        wr(A_CTRL, 32'h0, 0, ev);

        // R5 R7 period table
        for (int i = 0; i < NVEC; i++) begin
            int c1, c2;
            c1 = -1; c2 = -1;
            wr(A_CTRL, 32'h0, 0, ev);
            wr(A_CUR, 32'h0, 0, ev);
            refdiv = int'(VECS[i].div);
            wr(A_LOAD, VECS[i].reload, 0, ev);
            wr(A_CTRL, {29'd0, VECS[i].src[0], 2'b11}, 0, ev);
            for (int cyc = 0; cyc < 400; cyc++) begin
                @(negedge clk);
                if (irq === 1'b1) begin
                    if (c1 < 0) c1 = cyc;
                    else if (c2 < 0) c2 = cyc;
                end
            end
            check($sformatf("R5 R7 gap vector %0d", i), 32'(c2 - c1), VECS[i].gap);
        end

        // R6 R3 zero reload stops
        refdiv = 0;
        wr(A_CTRL, 32'h0, 0, ev);
        wr(A_CUR, 32'h0, 0, ev);
        wr(A_LOAD, 32'h0, 0, ev);
        wr(A_CTRL, 32'h7, 0, ev);
        begin
            int n;
            n = 0;
            for (int cyc = 0; cyc < 10; cyc++) begin
                @(negedge clk);
                if (irq === 1'b1) n++;
            end
            check("R6 single irq on zero reload", 32'(n), 32'd1);
        end
        rd(A_CTRL, 0, rv, ev); check("R6 R3 run cleared flag set", rv, 32'h0001_0006);
        rd(A_CTRL, 0, rv, ev); check("R3 flag cleared by read", rv, 32'h6);

        // R9 freeze and resume
        wr(A_LOAD, 32'd100, 0, ev);
        wr(A_CTRL, 32'h5, 0, ev);
        rd(A_CUR, 0, rv, ev); check("R9 load on start", rv, 32'd100);
        rd(A_CUR, 0, rv, ev); check("R9 counting", rv, 32'd99);
        wr(A_CTRL, 32'h4, 0, ev);
        rd(A_CUR, 0, rv, ev); check("R9 reads zero when stopped", rv, 32'd0);
        wr(A_CTRL, 32'h5, 0, ev);
        rd(A_CUR, 0, rv, ev); check("R9 resume frozen value", rv, 32'd98);
        rd(A_CUR, 0, rv, ev); check("R9 count after resume", rv, 32'd97);

        // R10 source change reloads; R7 no ref tick no step
        wr(A_CTRL, 32'h1, 0, ev);
        rd(A_CUR, 0, rv, ev); check("R10 reload on source change", rv, 32'd100);
        rd(A_CUR, 0, rv, ev); check("R7 idle without ref tick", rv, 32'd100);

        // R8 current write restarts and clears flag
        wr(A_LOAD, 32'd2, 0, ev);
        wr(A_CTRL, 32'h5, 0, ev);
        repeat (8) @(negedge clk);
        wr(A_CUR, 32'hABCD, 0, ev);
        rd(A_CUR, 0, rv, ev); check("R8 restart from reload", rv, 32'd2);
        rd(A_CTRL, 0, rv, ev); check("R8 flag cleared", rv, 32'h5);

        // R12 unprivileged accesses
        wr(A_LOAD, 32'h55, 1, ev); check("R12 write error", 32'(ev), 32'd1);
        rd(A_LOAD, 0, rv, ev); check("R12 write no effect", rv, 32'd2);
        check("R12 privileged no error", 32'(ev), 32'd0);
        rd(A_CTRL, 1, rv, ev);
        check("R12 read error", 32'(ev), 32'd1);
        check("R12 read data zero", rv, 32'h0);

        summary();
        $finish;
    end

endmodule